// File: doc/BRIEF.md
# Double to Single Precision Converter

This block narrows a 64-bit binary floating-point value (1 sign, 11 exponent, 52 fraction bits) to a 32-bit binary floating-point value (1 sign, 8 exponent, 23 fraction bits). It handles every input class. Normal values are rebiased and rounded. Values that are too large saturate to infinity or to the largest finite magnitude. Values that are too small become single-precision denormals or signed zeros. NaN and infinity are carried across as the same kind of value.

Rounding uses one of four modes chosen by a 2-bit select:

| Select | Mode |
| --- | --- |
| 0 | Nearest, ties to even (default) |
| 1 | Toward zero |
| 2 | Toward +infinity |
| 3 | Toward -infinity |

Each accepted operand produces a registered result one clock later. The result comes with a valid strobe and four exception flags: inexact, overflow, underflow and invalid.

Top module: `dp2sp_conv`

## Requirements
- R1: A normal input whose value fits single precision exactly keeps its sign. Its exponent is rebiased from excess-1023 to excess-127. The result fraction is the top 23 bits of the input fraction, and inexact stays 0.
- R2: In mode 0 (nearest-even), the bits dropped below the result LSB are compared with the halfway pattern. Below halfway truncates. Above halfway adds one LSB. Exactly halfway picks the candidate whose LSB is 0. Inexact is raised whenever a dropped bit is 1.
- R3: A rounding increment applied to an all-ones fraction carries into the exponent field and gives the next power of two.
- R4: Mode 1 never increases the magnitude. Mode 2 adds one LSB to positive inexact results only. Mode 3 adds one LSB to negative inexact results only.
- R5: A finite result whose biased exponent would reach 255 or more, before or after rounding, raises overflow and inexact. The result is infinity in modes 0, in mode 2 for positive inputs and in mode 3 for negative inputs. In all other cases it is the largest finite magnitude 0x7F7FFFFF with the input sign.
- R6: An input below the smallest single normal is shifted into denormal position and rounded once under the selected mode. A round-up may give the smallest normal 0x00800000. Underflow is raised when the input is below the smallest normal and the result is inexact.
- R7: A nonzero input far below the denormal range gives a signed zero, or the smallest denormal when a directed mode rounds away from zero. Inexact and underflow are both raised.
- R8: A NaN input gives a NaN with the same sign and with fraction bit 22 set. Fraction bits 21..0 are input fraction bits 50..29. Invalid is raised only when input fraction bit 51 was 0 (a signaling NaN).
- R9: An infinity or a zero input gives an infinity or a zero with the same sign and no flags.
- R10: Output valid is high exactly one cycle after input valid. The result and flags belong to that input. Synchronous active-high reset clears output valid, the result and all flags.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand valid strobe |
| in_op | input | 64 | Double-precision operand |
| rnd_mode | input | 2 | Rounding select (0 nearest-even, 1 toward zero, 2 up, 3 down) |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 32 | Single-precision result |
| flag_inexact | output | 1 | Result differs from the input value |
| flag_overflow | output | 1 | Magnitude exceeded single range |
| flag_underflow | output | 1 | Tiny and inexact |
| flag_invalid | output | 1 | Signaling NaN input |

## Verification
Two functions can act on the same operand: the rounding increment and the exponent update. When a fraction of all ones rounds up, the carry has to land in the exponent field. If that exponent is already at the top of the range, the carry also has to turn into overflow handling. At the bottom of the range, a denormal that rounds up has to become the smallest normal. The bench sets up each of these meeting points with directed operands under every rounding mode. It also applies several thousand operands with random exponents clustered around the single-precision range. Every output is compared, cycle by cycle, with a behavioural model that works on integer quantities and weight exponents rather than on bit fields.

// File: rtl/dp2sp_conv.sv
module dp2sp_conv #(
  parameter int DW = 64,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] in_op,
  input  logic [1:0]    rnd_mode,
  output logic          out_vld,
  output logic [SW-1:0] out_res,
  output logic          flag_inexact,
  output logic          flag_overflow,
  output logic          flag_underflow,
  output logic          flag_invalid
);
  logic               sgn;
  logic [10:0]        ex;
  logic [51:0]        fr;
  logic [52:0]        man;
  logic signed [12:0] ue;
  logic [12:0]        sh_full;
  logic               den, big;
  logic [5:0]         sh;
  logic [52:0]        shd, lost;
  logic [23:0]        kept;
  logic               grd, stk, inc, to_max, ovf;
  logic [7:0]         base;
  logic [30:0]        packed_v;
  logic [31:0]        res_c;
  logic               nx_c, of_c, uf_c, nv_c;

  assign sgn = in_op[63];
  assign ex  = in_op[62:52];
  assign fr  = in_op[51:0];
  assign man = {|ex, fr};
  assign ue  = $signed({2'b00, ex}) - 13'sd896;
  assign den = (ue <= 13'sd0);
  assign big = (ue >= 13'sd255);
  assign sh_full = 13'd1 - ue;
  assign sh  = !den ? 6'd0 : (sh_full > 13'd63 ? 6'd63 : sh_full[5:0]);
  assign shd  = man >> sh;
  assign lost = man & ~({53{1'b1}} << sh);
  assign kept = shd[52:29];
  assign grd  = shd[28];
  assign stk  = (|shd[27:0]) | (|lost);

  always_comb begin
    case (rnd_mode)
      2'd0:    inc = grd & (stk | kept[0]);
      2'd1:    inc = 1'b0;
      2'd2:    inc = ~sgn & (grd | stk);
      default: inc = sgn & (grd | stk);
    endcase
  end

  assign base     = kept[23] ? ue[7:0] : 8'd0;
  assign packed_v = {base, kept[22:0]} + {30'd0, inc};
  assign ovf      = big | (packed_v[30:23] == 8'hFF);
  assign to_max   = (rnd_mode == 2'd1) | (rnd_mode == 2'd2 & sgn) | (rnd_mode == 2'd3 & ~sgn);

  always_comb begin
    res_c = {sgn, packed_v};
    nx_c  = grd | stk;
    of_c  = 1'b0;
    uf_c  = den & (grd | stk);
    nv_c  = 1'b0;
    if (ex == 11'h7FF) begin
      nx_c = 1'b0;
      uf_c = 1'b0;
      if (|fr) begin
        res_c = {sgn, 8'hFF, 1'b1, fr[50:29]};
        nv_c  = ~fr[51];
      end else begin
        res_c = {sgn, 8'hFF, 23'd0};
      end
    end else if (ovf) begin
      res_c = to_max ? {sgn, 8'hFE, 23'h7FFFFF} : {sgn, 8'hFF, 23'd0};
      of_c  = 1'b1;
      nx_c  = 1'b1;
      uf_c  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld        <= 1'b0;
      out_res        <= '0;
      flag_inexact   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_invalid   <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res        <= res_c;
        flag_inexact   <= nx_c;
        flag_overflow  <= of_c;
        flag_underflow <= uf_c;
        flag_invalid   <= nv_c;
      end
    end
  end

  // R10
  vld_lat_chk: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld);
  // R10
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld);
  // R5
  ovf_nx_chk: assert property (@(posedge clk) disable iff (rst) flag_overflow |-> flag_inexact);
  // R6
  uf_nx_chk: assert property (@(posedge clk) disable iff (rst) flag_underflow |-> flag_inexact);
  // R8
  nv_nan_chk: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> (out_res[30:23] == 8'hFF && out_res[22]));
  // R5
  ovf_exp_chk: assert property (@(posedge clk) disable iff (rst)
    flag_overflow |-> (out_res[30:24] == 7'h7F && out_res[22:0] != 23'd1));
  // R4
  rz_noinf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && rnd_mode == 2'd1 && in_op[62:52] != 11'h7FF) |=> out_res[30:0] != 31'h7F800000);
endmodule

// File: tb/test_dp2sp_conv.sv
module test_dp2sp_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [63:0] in_op = '0;
  logic [1:0]  rnd_mode = '0;
  logic        out_vld;
  logic [31:0] out_res;
  logic        flag_inexact, flag_overflow, flag_underflow, flag_invalid;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dp2sp_conv i_dp2sp_conv (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .rnd_mode(rnd_mode),
    .out_vld(out_vld), .out_res(out_res), .flag_inexact(flag_inexact),
    .flag_overflow(flag_overflow), .flag_underflow(flag_underflow), .flag_invalid(flag_invalid)
  );

  // returns {invalid, overflow, underflow, inexact, result}
  function automatic logic [35:0] model(input logic [63:0] op, input logic [1:0] md);
    logic s;
    int e, unb, d, el, biased;
    logic [63:0] sig, keep, rem, half;
    logic up, nx;
    s = op[63];
    e = int'(op[62:52]);
    if (e == 2047) begin
      if (op[51:0] != 0) return {~op[51], 3'b000, s, 8'hFF, 1'b1, op[50:29]};
      return {4'b0000, s, 8'hFF, 23'd0};
    end
    sig = (e != 0 ? (64'd1 << 52) : 64'd0) | {12'd0, op[51:0]};
    unb = (e == 0) ? -1022 : e - 1023;
    d = 29 + ((unb < -126) ? (-126 - unb) : 0);
    if (d >= 62) begin
      keep = 0; rem = sig; half = 64'd1 << 61;
    end else begin
      keep = sig >> d; rem = sig & ((64'd1 << d) - 1); half = 64'd1 << (d - 1);
    end
    nx = (rem != 0);
    case (md)
      2'd0: up = (rem > half) || (rem == half && keep[0]);
      2'd1: up = 1'b0;
      2'd2: up = !s && nx;
      default: up = s && nx;
    endcase
    keep = keep + {63'd0, up};
    el = ((unb < -126) ? -126 : unb) - 23;
    if (keep == (64'd1 << 24)) begin keep = 64'd1 << 23; el = el + 1; end
    if (keep >= (64'd1 << 23)) begin
      biased = el + 150;
      if (biased >= 255) begin
        if (md == 2'd1 || (md == 2'd2 && s) || (md == 2'd3 && !s))
          return {4'b0101, s, 8'hFE, 23'h7FFFFF};
        return {4'b0101, s, 8'hFF, 23'd0};
      end
      return {2'b00, nx && unb < -126, nx, s, biased[7:0], keep[22:0]};
    end
    return {2'b00, nx && unb < -126, nx, s, 8'd0, keep[22:0]};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual {nv,of,uf,nx,res}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic conv(input string tag, input logic [63:0] op, input logic [1:0] md);
    logic [35:0] exp;
    exp = model(op, md);
    @(negedge clk);
    in_vld = 1'b1; in_op = op; rnd_mode = md;
    @(negedge clk);
    in_vld = 1'b0;
    check({tag, " valid"}, {35'd0, out_vld}, 36'd1);
    check(tag, {flag_invalid, flag_overflow, flag_underflow, flag_inexact, out_res}, exp);
  endtask

  task automatic conv_lit(input string tag, input logic [63:0] op, input logic [1:0] md,
                          input logic [35:0] exp);
    @(negedge clk);
    in_vld = 1'b1; in_op = op; rnd_mode = md;
    @(negedge clk);
    in_vld = 1'b0;
    check(tag, {flag_invalid, flag_overflow, flag_underflow, flag_inexact, out_res}, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {out_vld, flag_invalid, flag_overflow, flag_underflow, flag_inexact, out_res}, 37'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle", {35'd0, out_vld}, 36'd0);
    conv_lit("R1 one", 64'h3FF0000000000000, 2'd0, {4'b0000, 32'h3F800000});
    conv_lit("R1 -1.5", 64'hBFF8000000000000, 2'd0, {4'b0000, 32'hBFC00000});
    conv_lit("R2 below half", 64'h3FF000000FFFFFFF, 2'd0, {4'b0001, 32'h3F800000});
    conv_lit("R2 above half", 64'h3FF0000018000000, 2'd0, {4'b0001, 32'h3F800001});
    conv_lit("R2 tie even stays", 64'h3FF0000010000000, 2'd0, {4'b0001, 32'h3F800000});
    conv_lit("R2 tie odd up", 64'h3FF0000030000000, 2'd0, {4'b0001, 32'h3F800002});
    conv_lit("R3 carry to exp", 64'h3FFFFFFFF0000000, 2'd0, {4'b0001, 32'h40000000});
    conv_lit("R4 rz neg", 64'hBFF0000008000000, 2'd1, {4'b0001, 32'hBF800000});
    conv_lit("R4 up neg", 64'hBFF0000008000000, 2'd2, {4'b0001, 32'hBF800000});
    conv_lit("R4 down neg", 64'hBFF0000008000000, 2'd3, {4'b0001, 32'hBF800001});
    conv_lit("R4 up pos", 64'h3FF0000008000000, 2'd2, {4'b0001, 32'h3F800001});
    conv_lit("R5 big rne", 64'h47F0000000000000, 2'd0, {4'b0101, 32'h7F800000});
    conv_lit("R5 big rz", 64'h47F0000000000000, 2'd1, {4'b0101, 32'h7F7FFFFF});
    conv_lit("R5 neg up", 64'hC7F0000000000000, 2'd2, {4'b0101, 32'hFF7FFFFF});
    conv_lit("R5 neg down", 64'hC7F0000000000000, 2'd3, {4'b0101, 32'hFF800000});
    conv_lit("R5 round ovf", 64'h47EFFFFFF0000000, 2'd0, {4'b0101, 32'h7F800000});
    conv_lit("R5 max exact", 64'h47EFFFFFE0000000, 2'd0, {4'b0000, 32'h7F7FFFFF});
    conv_lit("R6 exact denorm", 64'h37D0000000000000, 2'd0, {4'b0000, 32'h00080000});
    conv_lit("R6 denorm up", 64'h37D0000000000001, 2'd2, {4'b0011, 32'h00080001});
    conv_lit("R6 to min normal", 64'h380FFFFFFFFFFFFF, 2'd0, {4'b0011, 32'h00800000});
    conv_lit("R7 tiny rne", 64'h0000000000000001, 2'd0, {4'b0011, 32'h00000000});
    conv_lit("R7 tiny up", 64'h0000000000000001, 2'd2, {4'b0011, 32'h00000001});
    conv_lit("R7 neg tiny down", 64'h8000000000000001, 2'd3, {4'b0011, 32'h80000001});
    conv_lit("R8 quiet nan", 64'h7FF8000000000000, 2'd0, {4'b0000, 32'h7FC00000});
    conv_lit("R8 signaling nan", 64'hFFF0000000000001, 2'd1, {4'b1000, 32'hFFC00000});
    conv_lit("R8 payload", 64'h7FF4000000000000, 2'd0, {4'b1000, 32'h7FE00000});
    conv_lit("R9 inf", 64'h7FF0000000000000, 2'd2, {4'b0000, 32'h7F800000});
    conv_lit("R9 neg zero", 64'h8000000000000000, 2'd0, {4'b0000, 32'h80000000});
    @(negedge clk);
    check("R10 gap", {35'd0, out_vld}, 36'd0);
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] op;
      op = {$urandom, $urandom};
      if (k % 4 != 0) op[62:52] = 11'(860 + ($urandom % 330));
      if (k % 16 == 1) op[28:0] = (k % 32 == 1) ? 29'h10000000 : 29'h0;
      conv("R2 R4 R6 random", op, 2'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule